// File: doc/BRIEF.md
# Serial Register Interface with Frame-Length Check

This block is the slave side of a four-wire serial link into a multi-channel output driver controller. A host writes 24-bit words into one of two control registers and, during the same frame, reads back one of two status registers. Words travel least significant bit first in both directions. The link uses clock idle low, input sampled on the rising edge and output changed on the falling edge. The serial pins are brought into a faster system clock through two-flop synchronizers, and all edge detection happens in that clock domain.

Any frame that does not carry exactly the configured number of clock pulses is dropped whole, so a truncated or overlong transfer never reaches the control registers. As soon as chip select falls, the data output drives a one-bit health summary. A host can therefore poll the device without clocking a full frame. Two control bits are decoded inside the block. The top bit of every accepted word keeps the interface active, and a zero there puts it into standby, which wipes all latched data. The next bit down, in a bank-0 word, clears both status registers once the frame ends.

Status registers collect sticky flags from parallel inputs supplied by the fault logic. Each accepted write is also presented on a one-cycle strobe, together with the word and the bank select, so that downstream logic can latch it on a single event.

Top module: `spi_frame_regif`

## Requirements
- R1: Clock idle level is low. DI is taken on each rising serial-clock edge, and DO moves to its next bit only on falling serial-clock edges.
- R2: Words are shifted least significant bit first. The first DI bit becomes word bit 0, and the first bit on DO is status bit 0.
- R3: On the CSN rising edge of a frame with exactly FRAME_BITS rising clock edges, `wr_stb_o` pulses for one cycle with the received word on `wr_data_o` and word bit 0 on `wr_sel_o`. The word is then latched into the selected control register.
- R4: A frame with fewer or more rising clock edges than FRAME_BITS, including one far longer than FRAME_BITS, produces no strobe and changes no register. The edge counter saturates one above FRAME_BITS.
- R5: While CSN is high, `sdo_en_o` is 0. After CSN falls, `sdo_en_o` is 1 and DO shows status bit 0, the fault summary, for as long as no clock edge arrives.
- R6: Word bit 0 selects the bank: 0 for control/status bank 0 and 1 for bank 1. The status register read out during a frame is the one named by the first DI bit of that same frame.
- R7: A status word reads bit 23 (the top bit) as 1. Bits 1..22 hold sticky flags captured from the matching status-set inputs. Bit 0 is 1 only when bits 1..22 of both status registers are all zero.
- R8: An accepted active bank-0 word with bit 22 set clears both status registers after its CSN rising edge and pulses `clr_stat_o`. The data read out during that frame is the pre-clear content. Bit 22 in a bank-1 word clears nothing.
- R9: Reset, or an accepted word with bit 23 clear, enters standby (`standby_o`=1). This zeroes both control registers and both status registers. Status-set inputs are ignored while in standby.
- R10: An accepted word with bit 23 set leaves standby (`standby_o`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| csn_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out (valid when enabled) |
| sdo_en_o | output | 1 | Output enable for the DO pad driver; 0 means high impedance |
| stat_set0_i | input | FRAME_BITS | Sticky flag set requests for status bank 0 (bits 1..22 used) |
| stat_set1_i | input | FRAME_BITS | Sticky flag set requests for status bank 1 (bits 1..22 used) |
| ctrl0_o | output | FRAME_BITS | Control register bank 0 |
| ctrl1_o | output | FRAME_BITS | Control register bank 1 |
| wr_stb_o | output | 1 | One-cycle pulse for each accepted frame |
| wr_sel_o | output | 1 | Bank select of the accepted frame |
| wr_data_o | output | FRAME_BITS | Word of the accepted frame |
| standby_o | output | 1 | Standby state |
| clr_stat_o | output | 1 | One-cycle pulse when the reset bit clears status |

## Verification
The bench builds the block with its defaults: FRAME_BITS of 24 and SYNC_STAGES of 2. With a word that narrow, a 40-pulse frame drives the edge counter past its saturation point, so the saturation path is exercised. Frames of 23 and 25 pulses probe the boundaries on either side of the accepted length. Two synchronizer stages plus the edge register keep the serial-to-system latency short. At eight system clocks per serial half period, every DO bit has settled before it is sampled, and the idle poll window with CSN low is long enough to confirm the held fault bit.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

  typedef enum logic {
    SEL_BANK0 = 1'b0,
    SEL_BANK1 = 1'b1
  } bank_sel_e;

  localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[g]}};
      else     chain <= {chain[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
  parameter int unsigned FRAME_BITS = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  csn_s,
  input  logic                  sclk_s,
  input  logic                  sdi_s,
  input  logic [FRAME_BITS-1:0] stat0_w,
  input  logic [FRAME_BITS-1:0] stat1_w,
  input  logic                  fault,
  output logic                  sdo_o,
  output logic                  sdo_en_o,
  output logic                  wr_stb_o,
  output logic                  wr_sel_o,
  output logic [FRAME_BITS-1:0] wr_data_o
);

  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);

  logic                  csn_q, sclk_q;
  logic [CNT_W-1:0]      cnt;
  logic [FRAME_BITS-1:0] in_sh, out_sh;
  logic                  idle_q, sdo_q, en_q;
  logic                  cs_fall, cs_rise, ck_rise, ck_fall;

  assign cs_fall = csn_q & ~csn_s;
  assign cs_rise = ~csn_q & csn_s;
  assign ck_rise = ~sclk_q & sclk_s & ~csn_s;
  assign ck_fall = sclk_q & ~sclk_s & ~csn_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      csn_q     <= 1'b1;
      sclk_q    <= 1'b0;
      cnt       <= '0;
      in_sh     <= '0;
      out_sh    <= '0;
      idle_q    <= 1'b1;
      sdo_q     <= 1'b0;
      en_q      <= 1'b0;
      wr_stb_o  <= 1'b0;
      wr_sel_o  <= 1'b0;
      wr_data_o <= '0;
    end else begin
      csn_q    <= csn_s;
      sclk_q   <= sclk_s;
      en_q     <= ~csn_s;
      wr_stb_o <= 1'b0;
      if (cs_fall) begin
        cnt    <= '0;
        idle_q <= 1'b1;
        sdo_q  <= fault;
      end else if (!csn_s) begin
        if (ck_rise) begin
          in_sh <= {sdi_s, in_sh[FRAME_BITS-1:1]};
          if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
          if (idle_q) begin
            idle_q <= 1'b0;
            out_sh <= (sdi_s ? stat1_w : stat0_w) >> 1;
          end
        end else if (ck_fall && !idle_q) begin
          sdo_q  <= out_sh[0];
          out_sh <= {1'b0, out_sh[FRAME_BITS-1:1]};
        end else if (idle_q) begin
          sdo_q <= fault;
        end
      end
      if (cs_rise && cnt == CNT_FULL) begin
        wr_stb_o  <= 1'b1;
        wr_data_o <= in_sh;
        wr_sel_o  <= in_sh[0];
      end
    end
  end

  assign sdo_o    = sdo_q;
  assign sdo_en_o = en_q;

  assert_wr_exact_len_R3: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |-> ($past(cnt) == CNT_FULL));

  assert_cnt_saturates_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_SAT);

  assert_idle_fault_held_R5: assert property (@(posedge clk) disable iff (rst)
    (idle_q && !csn_s && !csn_q && !ck_rise && $stable(fault)) |=> $stable(sdo_q));

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_regif_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_stb,
  input  logic                  wr_sel,
  input  logic [FRAME_BITS-1:0] wr_data,
  input  logic [FRAME_BITS-1:0] set0,
  input  logic [FRAME_BITS-1:0] set1,
  output logic [FRAME_BITS-1:0] ctrl0,
  output logic [FRAME_BITS-1:0] ctrl1,
  output logic                  standby,
  output logic                  clr_stat,
  output logic [FRAME_BITS-1:0] stat0_w,
  output logic [FRAME_BITS-1:0] stat1_w,
  output logic                  fault
);

  localparam int unsigned EN_BIT  = FRAME_BITS - 1;
  localparam int unsigned CLR_BIT = FRAME_BITS - 2;
  localparam logic [FRAME_BITS-1:0] STICKY_MASK = {1'b0, {(FRAME_BITS-2){1'b1}}, 1'b0};

  logic [FRAME_BITS-1:0] ctrl_q [NUM_BANKS];
  logic [FRAME_BITS-1:0] st_q   [NUM_BANKS];
  logic [FRAME_BITS-1:0] set_v  [NUM_BANKS];
  logic                  standby_q, clr_q;
  logic                  accept_active, go_standby, clr_req;

  assign set_v[0] = set0;
  assign set_v[1] = set1;

  assign accept_active = wr_stb & wr_data[EN_BIT];
  assign go_standby    = wr_stb & ~wr_data[EN_BIT];
  assign clr_req       = accept_active & (bank_sel_e'(wr_sel) == SEL_BANK0) & wr_data[CLR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      standby_q <= 1'b1;
      clr_q     <= 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        ctrl_q[b] <= '0;
        st_q[b]   <= '0;
      end
    end else begin
      clr_q <= clr_req;
      if (go_standby)         standby_q <= 1'b1;
      else if (accept_active) standby_q <= 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (go_standby)
          ctrl_q[b] <= '0;
        else if (accept_active && wr_sel == b[0])
          ctrl_q[b] <= wr_data;
        if (go_standby || clr_req || standby_q)
          st_q[b] <= '0;
        else
          st_q[b] <= st_q[b] | (set_v[b] & STICKY_MASK);
      end
    end
  end

  assign fault   = ~|((st_q[0] | st_q[1]) & STICKY_MASK);
  assign stat0_w = {1'b1, st_q[0][FRAME_BITS-2:1], fault};
  assign stat1_w = {1'b1, st_q[1][FRAME_BITS-2:1], fault};

  assign ctrl0    = ctrl_q[0];
  assign ctrl1    = ctrl_q[1];
  assign standby  = standby_q;
  assign clr_stat = clr_q;

  assert_write_bank0_R6: assert property (@(posedge clk) disable iff (rst)
    (accept_active && !wr_sel) |=> (ctrl_q[0] == $past(wr_data)) && $stable(ctrl_q[1]));

  assert_status_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> (st_q[0] == '0) && (st_q[1] == '0) && clr_q);

  assert_standby_wipe_R9: assert property (@(posedge clk) disable iff (rst)
    go_standby |=> standby_q && (ctrl_q[0] == '0) && (ctrl_q[1] == '0) && (st_q[0] == '0));

  assert_leave_standby_R10: assert property (@(posedge clk) disable iff (rst)
    accept_active |=> !standby_q);

endmodule

// File: rtl/spi_frame_regif.sv
module spi_frame_regif #(
  parameter int unsigned FRAME_BITS  = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  csn_i,
  input  logic                  sclk_i,
  input  logic                  sdi_i,
  output logic                  sdo_o,
  output logic                  sdo_en_o,
  input  logic [FRAME_BITS-1:0] stat_set0_i,
  input  logic [FRAME_BITS-1:0] stat_set1_i,
  output logic [FRAME_BITS-1:0] ctrl0_o,
  output logic [FRAME_BITS-1:0] ctrl1_o,
  output logic                  wr_stb_o,
  output logic                  wr_sel_o,
  output logic [FRAME_BITS-1:0] wr_data_o,
  output logic                  standby_o,
  output logic                  clr_stat_o
);

  logic [2:0]            pins_s;
  logic [FRAME_BITS-1:0] stat0_w, stat1_w;
  logic                  fault;

  spi_pin_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({csn_i, sclk_i, sdi_i}),
    .q_o (pins_s)
  );

  spi_frame_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .csn_s     (pins_s[2]),
    .sclk_s    (pins_s[1]),
    .sdi_s     (pins_s[0]),
    .stat0_w   (stat0_w),
    .stat1_w   (stat1_w),
    .fault     (fault),
    .sdo_o     (sdo_o),
    .sdo_en_o  (sdo_en_o),
    .wr_stb_o  (wr_stb_o),
    .wr_sel_o  (wr_sel_o),
    .wr_data_o (wr_data_o)
  );

  spi_reg_bank #(.FRAME_BITS(FRAME_BITS)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_stb   (wr_stb_o),
    .wr_sel   (wr_sel_o),
    .wr_data  (wr_data_o),
    .set0     (stat_set0_i),
    .set1     (stat_set1_i),
    .ctrl0    (ctrl0_o),
    .ctrl1    (ctrl1_o),
    .standby  (standby_o),
    .clr_stat (clr_stat_o),
    .stat0_w  (stat0_w),
    .stat1_w  (stat1_w),
    .fault    (fault)
  );

endmodule

// File: tb/tb_spi_frame_regif.sv
module tb_spi_frame_regif;

  localparam int CLK_PERIOD = 10;
  localparam int FB         = 24;
  localparam int HALF       = 8;
  localparam logic [FB-1:0] MASK = {1'b0, {(FB-2){1'b1}}, 1'b0};

  logic          clk = 1'b0;
  logic          rst, csn, sclk, sdi;
  logic          sdo, sdo_en;
  logic [FB-1:0] set0, set1;
  logic [FB-1:0] ctrl0, ctrl1, wr_data;
  logic          wr_stb, wr_sel, standby, clr_stat;

  int n_chk = 0;
  int n_fail = 0;
  int wr_seen = 0;
  int clr_seen = 0;
  int wr_exp = 0;
  logic [FB:0]   exp_q[$];
  logic [FB-1:0] m_st0 = '0, m_st1 = '0;
  logic          m_standby = 1'b1;

  spi_frame_regif #(.FRAME_BITS(FB), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .csn_i(csn), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_en_o(sdo_en), .stat_set0_i(set0), .stat_set1_i(set1),
    .ctrl0_o(ctrl0), .ctrl1_o(ctrl1), .wr_stb_o(wr_stb), .wr_sel_o(wr_sel),
    .wr_data_o(wr_data), .standby_o(standby), .clr_stat_o(clr_stat)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [FB-1:0] rd_word(input bit sel);
    logic f;
    f = ~|((m_st0 | m_st1) & MASK);
    return {1'b1, (sel ? m_st1[FB-2:1] : m_st0[FB-2:1]), f};
  endfunction

  task automatic pulse_stat(input logic [FB-1:0] s0, input logic [FB-1:0] s1);
    set0 = s0; set1 = s1;
    wait_clk(1);
    set0 = '0; set1 = '0;
    wait_clk(2);
    if (!m_standby) begin
      m_st0 |= s0 & MASK;
      m_st1 |= s1 & MASK;
    end
  endtask

  // Driver: runs a frame, pushes the expected write into the scoreboard.
  task automatic spi_frame(input logic [FB-1:0] word, input int nclk,
                           input logic [FB-1:0] exp_rd, input bit chk_rd, input string req);
    logic [FB-1:0] got;
    got = '0;
    if (nclk == FB) begin
      exp_q.push_back({word[0], word});
      wr_exp++;
    end
    csn = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nclk; i++) begin
      sclk = 1'b0;
      sdi  = (i < FB) ? word[i] : 1'b0;
      wait_clk(HALF);
      if (i < FB) got[i] = sdo;
      sclk = 1'b1;
      wait_clk(HALF);
    end
    sclk = 1'b0;
    wait_clk(HALF);
    csn = 1'b1;
    wait_clk(HALF);
    if (chk_rd) check(got == exp_rd, req, 32'(got), 32'(exp_rd));
  endtask

  // Monitor: compares each write strobe against the scoreboard.
  always @(negedge clk) begin
    if (rst === 1'b0) begin
      if (clr_stat) clr_seen++;
      if (wr_stb) begin
        wr_seen++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R3/R4 unexpected write strobe", 32'(wr_data), 32'h0);
        end else begin
          logic [FB:0] e;
          e = exp_q.pop_front();
          check({wr_sel, wr_data} == e, "R3/R6 strobe word and select",
                32'({wr_sel, wr_data}), 32'(e));
        end
      end
    end
  end

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; csn = 1'b1; sclk = 1'b0; sdi = 1'b0; set0 = '0; set1 = '0;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);

    // Reset state: standby, cleared registers, DO not driven
    check(standby == 1'b1, "R9 reset standby", 32'(standby), 32'h1);
    check(ctrl0 == '0 && ctrl1 == '0, "R9 reset control clear", 32'(ctrl0 | ctrl1), 32'h0);
    check(sdo_en == 1'b0, "R5 hi-z while CSN high", 32'(sdo_en), 32'h0);

    // Status inputs ignored in standby
    pulse_stat(24'h000010, 24'h000000);

    // Fault poll with no errors: bit 0 reads 1
    csn = 1'b0; wait_clk(HALF);
    check(sdo_en == 1'b1 && sdo == 1'b1, "R5 poll fault bit no error", 32'({sdo_en, sdo}), 32'h3);
    csn = 1'b1; wait_clk(HALF);
    check(wr_seen == wr_exp, "R4 zero-clock poll writes nothing", 32'(wr_seen), 32'(wr_exp));

    // Bank 0 write, leaves standby; readback of status bank 0
    spi_frame(24'h801234, FB, rd_word(1'b0), 1'b1, "R1/R2/R6/R9 read status0");
    check(ctrl0 == 24'h801234, "R3 ctrl0 written", 32'(ctrl0), 32'h801234);
    check(standby == 1'b0, "R10 active after enable word", 32'(standby), 32'h0);
    m_standby = 1'b0;

    // Raise flags, then poll: fault bit 0 held low with no clocks
    pulse_stat(24'h000020, 24'h000400);
    csn = 1'b0; wait_clk(HALF);
    check(sdo_en == 1'b1 && sdo == 1'b0, "R5 poll shows fault", 32'({sdo_en, sdo}), 32'h2);
    wait_clk(20);
    check(sdo == 1'b0, "R5 fault held without clocks", 32'(sdo), 32'h0);
    csn = 1'b1; wait_clk(HALF);
    check(sdo_en == 1'b0, "R5 hi-z after CSN rise", 32'(sdo_en), 32'h0);

    // Bank 1 write and status bank 1 readback
    spi_frame(24'h8000F1, FB, rd_word(1'b1), 1'b1, "R1/R2/R6/R7 read status1");
    check(ctrl1 == 24'h8000F1 && ctrl0 == 24'h801234, "R6 bank 1 written only",
          32'(ctrl1), 32'h8000F1);

    // Length violations
    spi_frame(24'h80AAAA, FB - 1, '0, 1'b0, "R4");
    check(ctrl0 == 24'h801234 && wr_seen == wr_exp, "R4 short frame dropped", 32'(ctrl0), 32'h801234);
    spi_frame(24'h80AAAA, FB + 1, '0, 1'b0, "R4");
    check(ctrl0 == 24'h801234 && wr_seen == wr_exp, "R4 long frame dropped", 32'(ctrl0), 32'h801234);
    spi_frame(24'h80AAAA, 40, '0, 1'b0, "R4");
    check(ctrl0 == 24'h801234 && wr_seen == wr_exp, "R4 saturated frame dropped", 32'(ctrl0), 32'h801234);

    // Reset bit in bank 0: pre-clear data read out, then cleared
    spi_frame(24'hC00002, FB, rd_word(1'b0), 1'b1, "R8 pre-clear readout");
    m_st0 = '0; m_st1 = '0;
    check(clr_seen == 1, "R8 clear pulse", 32'(clr_seen), 32'h1);
    spi_frame(24'h800003, FB, rd_word(1'b1), 1'b1, "R8 status cleared");

    // Bit 22 in bank 1 does not clear
    pulse_stat(24'h000000, 24'h000080);
    spi_frame(24'hC00001, FB, rd_word(1'b1), 1'b1, "R8 bank1 readout");
    spi_frame(24'h800000, FB, rd_word(1'b0), 1'b1, "R7 fault from other bank");
    spi_frame(24'h800001, FB, rd_word(1'b1), 1'b1, "R8 bank1 bit22 no clear");
    check(clr_seen == 1, "R8 no extra clear", 32'(clr_seen), 32'h1);

    // Standby entry wipes everything
    spi_frame(24'h000001, FB, rd_word(1'b1), 1'b1, "R9 readout before standby");
    m_standby = 1'b1; m_st0 = '0; m_st1 = '0;
    check(standby == 1'b1, "R9 standby entered", 32'(standby), 32'h1);
    check(ctrl0 == '0 && ctrl1 == '0, "R9 control wiped", 32'(ctrl0 | ctrl1), 32'h0);
    pulse_stat(24'h000008, 24'h000008);
    spi_frame(24'h800000, FB, rd_word(1'b0), 1'b1, "R9 flags ignored in standby");
    m_standby = 1'b0;

    wait_clk(10);
    check(exp_q.size() == 0 && wr_seen == wr_exp, "R3 all expected writes seen",
          32'(wr_seen), 32'(wr_exp));
    finish_run();
  end

endmodule